// File: doc/BRIEF.md
# Multichannel TDM Serial Input Demultiplexer

This block takes a single serial data line together with its bit clock and frame sync and splits each frame into sixteen logical channels. The frame is 64, 128, 192 or 256 bits long. Every channel picks out its own window of bits in each frame. The window is defined by an 8-bit start position and a sample length of 1, 2, 4 or 8 bits. Those bits are shifted into a private 16-bit shift register. Once a full word has accumulated, which can take several frames, the word is copied into a per-channel read register. The host therefore always sees a stable previous word while the next one is being built.

All logic runs on one system clock. The bit clock, frame sync and data are synchronized, and the bit clock is edge-detected. Configuration comes in as plain register-style inputs that a surrounding register file drives: frame size code, packed start positions, length codes and a word-size select. A one-cycle load strobe per channel marks every update of a read register.

Top module: `tdm_demux`

## Requirements
- R1: The frame size code `cfg_frame_size` selects 64 (00), 128 (01), 192 (10) or 256 (11) bits per frame. The frame bit index counts 0 up to size-1 and then wraps to 0 without needing a new frame sync.
- R2: Serial input is ignored, with no capture and no load, until the first rising edge of `fsync_in` after reset. `frame_valid` is 0 until that point and 1 after the first frame bit is taken.
- R3: Each frame bit is the value of `sdata_in` at a falling edge of `bclk_in`. A value present only while `bclk_in` is high and changed before the falling edge is not captured.
- R4: A channel captures the frame bits whose index i satisfies start <= i < start + length. For example, start 63 with length 2 captures bits 63 and 64.
- R5: A channel's 2-bit length code in `cfg_len_codes[2c+1:2c]` maps 00 to 1 bit, 01 to 2 bits, 10 to 4 bits and 11 to 8 bits per frame. In 16-bit mode this gives a read-register update every 16, 8, 4 or 2 frames.
- R6: Channel c takes its start position from `cfg_start[8c+7:8c]`. Each 16-bit group therefore holds an even channel in its low byte and the next odd channel in its high byte.
- R7: When a channel has captured a full word, its read register is loaded with the captured bits and `rd_load[c]` pulses for one cycle. The first captured bit ends up as the most significant data bit.
- R8: With `cfg_byte_mode` = 1, a load happens after 8 captured bits. The byte is right-justified in the read register and the upper byte reads as zero. With `cfg_byte_mode` = 0, a load happens after 16 bits.
- R9: A read register keeps its value in every cycle in which its load strobe is low.
- R10: Synchronous reset `rst` clears all read registers, shift registers, bit counts and `frame_valid`.
- R11: A rising edge of `fsync_in` in the middle of a frame restarts the bit index at 0 on the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_in | input | 1 | Serial bit clock, asynchronous to clk |
| fsync_in | input | 1 | Frame sync, rising edge marks bit 0 |
| sdata_in | input | 1 | Serial data |
| cfg_frame_size | input | 2 | Frame size code |
| cfg_start | input | NUM_CH*8 | Start bit positions, 8 bits per channel |
| cfg_len_codes | input | NUM_CH*2 | Sample length codes, 2 bits per channel |
| cfg_byte_mode | input | 1 | 1 selects 8-bit words, 0 selects 16-bit words |
| rd_data | output | NUM_CH*WORD_W | Per-channel read registers, channel c at [16c+15:16c] |
| rd_load | output | NUM_CH | One-cycle strobe per channel on a read register load |
| frame_valid | output | 1 | A frame start has been seen since reset |

## Verification
The bench goes after several corner cases. The first is bits sent before any frame sync: a design that counts them would produce loads with no matching expected item. The second is a data line that carries a junk value while the bit clock is high: a rising-edge sampler would shift in inverted bits. The third is a start position of 63 with length 2, and windows that run past the end of the frame: an off-by-one in the window compare shifts every word. The bench also runs 192-bit frames that wrap without a new sync and a frame sync that cuts a frame short; a counter that wraps at the wrong size or ignores the restart misplaces every later bit. Byte mode is checked for an early load with a zero upper byte. Read registers are compared at the end of each phase against the last expected word, which catches a channel that reads the wrong start byte or loses its held value.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  localparam int IDX_W  = 8;
  localparam int SIZE_W = 2;
  localparam int LEN_W  = 2;

  // Number of bits a channel takes per frame: 1, 2, 4 or 8
  function automatic logic [IDX_W:0] len_bits(input logic [LEN_W-1:0] code);
    return (IDX_W+1)'(1) << code;
  endfunction

  // Index of the final bit of a frame: 63, 127, 191 or 255
  function automatic logic [IDX_W-1:0] last_index(input logic [SIZE_W-1:0] sz);
    return {sz, 6'h3F};
  endfunction

  // Bits to accumulate before a read register load
  function automatic int unsigned word_target(input logic byte_mode, input int unsigned word_w);
    return byte_mode ? (word_w / 2) : word_w;
  endfunction

  // True when idx lies in [start, start+len)
  function automatic logic in_window(input logic [IDX_W-1:0] idx,
                                     input logic [IDX_W-1:0] start,
                                     input logic [IDX_W:0]   len);
    logic [IDX_W:0] i_w;
    logic [IDX_W:0] s_w;
    i_w = {1'b0, idx};
    s_w = {1'b0, start};
    return (i_w >= s_w) && (i_w < (s_w + len));
  endfunction

endpackage

// File: rtl/tdm_front.sv
module tdm_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic fsync_in,
  input  logic sdata_in,
  output logic bit_tick,
  output logic sync_rise,
  output logic bit_val
);

  localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [S-1:0] bclk_sr;
  logic [S-1:0] fsync_sr;
  logic [S-1:0] sdata_sr;
  logic         bclk_d;
  logic         fsync_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_sr  <= '0;
      fsync_sr <= '0;
      sdata_sr <= '0;
      bclk_d   <= 1'b0;
      fsync_d  <= 1'b0;
    end else begin
      bclk_sr  <= {bclk_sr[S-2:0], bclk_in};
      fsync_sr <= {fsync_sr[S-2:0], fsync_in};
      sdata_sr <= {sdata_sr[S-2:0], sdata_in};
      bclk_d   <= bclk_sr[S-1];
      fsync_d  <= fsync_sr[S-1];
    end
  end

  assign bit_tick  = bclk_d & ~bclk_sr[S-1];
  assign sync_rise = ~fsync_d & fsync_sr[S-1];
  assign bit_val   = sdata_sr[S-1];

endmodule

// File: rtl/tdm_bitcnt.sv
module tdm_bitcnt
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              sync_rise,
  input  logic [SIZE_W-1:0] cfg_frame_size,
  output logic              cap_en,
  output logic              start_take,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              frame_valid
);

  logic             pending;
  logic [IDX_W-1:0] cnt_q;

  assign start_take = bit_tick & (pending | sync_rise);
  assign cap_en     = bit_tick & (start_take | frame_valid);

  always_comb begin
    if (start_take)
      cur_idx = '0;
    else if (cnt_q == last_index(cfg_frame_size))
      cur_idx = '0;
    else
      cur_idx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending     <= 1'b0;
      frame_valid <= 1'b0;
      cnt_q       <= '0;
    end else begin
      if (bit_tick)
        pending <= 1'b0;
      else if (sync_rise)
        pending <= 1'b1;
      if (start_take)
        frame_valid <= 1'b1;
      if (cap_en)
        cnt_q <= cur_idx;
    end
  end

endmodule

// File: rtl/tdm_lane.sv
module tdm_lane
  import tdm_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [IDX_W-1:0]  start_pos,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              byte_mode,
  input  logic              bit_val,
  output logic              qual,
  output logic [WORD_W-1:0] rd_word,
  output logic              load_pulse
);

  localparam int HALF_W = WORD_W / 2;
  localparam int GOT_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shift_nx;
  logic [GOT_W-1:0]  got;
  logic [GOT_W-1:0]  got_nx;
  logic [GOT_W-1:0]  tgt;
  logic              word_done;

  assign qual      = cap_en & in_window(cur_idx, start_pos, len_bits(len_code));
  assign shift_nx  = {shreg[WORD_W-2:0], bit_val};
  assign got_nx    = got + 1'b1;
  assign tgt       = GOT_W'(word_target(byte_mode, WORD_W));
  assign word_done = qual & (got_nx == tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      got        <= '0;
      rd_word    <= '0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= 1'b0;
      if (qual) begin
        shreg <= shift_nx;
        got   <= word_done ? '0 : got_nx;
      end
      if (word_done) begin
        load_pulse <= 1'b1;
        if (byte_mode)
          rd_word <= {{(WORD_W-HALF_W){1'b0}}, shift_nx[HALF_W-1:0]};
        else
          rd_word <= shift_nx;
      end
    end
  end

endmodule

// File: rtl/tdm_demux.sv
module tdm_demux
  import tdm_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bclk_in,
  input  logic                     fsync_in,
  input  logic                     sdata_in,
  input  logic [SIZE_W-1:0]        cfg_frame_size,
  input  logic [NUM_CH*IDX_W-1:0]  cfg_start,
  input  logic [NUM_CH*LEN_W-1:0]  cfg_len_codes,
  input  logic                     cfg_byte_mode,
  output logic [NUM_CH*WORD_W-1:0] rd_data,
  output logic [NUM_CH-1:0]        rd_load,
  output logic                     frame_valid
);

  // Internal events brought out for the checker
  logic             bit_tick;
  logic             sync_rise;
  logic             bit_val;
  logic             cap_en;
  logic             start_take;
  logic [IDX_W-1:0] cur_idx;
  logic [NUM_CH-1:0] qual_vec;

  tdm_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst       (rst),
    .bclk_in   (bclk_in),
    .fsync_in  (fsync_in),
    .sdata_in  (sdata_in),
    .bit_tick  (bit_tick),
    .sync_rise (sync_rise),
    .bit_val   (bit_val)
  );

  tdm_bitcnt u_cnt (
    .clk            (clk),
    .rst            (rst),
    .bit_tick       (bit_tick),
    .sync_rise      (sync_rise),
    .cfg_frame_size (cfg_frame_size),
    .cap_en         (cap_en),
    .start_take     (start_take),
    .cur_idx        (cur_idx),
    .frame_valid    (frame_valid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    tdm_lane #(.WORD_W(WORD_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .cap_en     (cap_en),
      .cur_idx    (cur_idx),
      .start_pos  (cfg_start[c*IDX_W +: IDX_W]),
      .len_code   (cfg_len_codes[c*LEN_W +: LEN_W]),
      .byte_mode  (cfg_byte_mode),
      .bit_val    (bit_val),
      .qual       (qual_vec[c]),
      .rd_word    (rd_data[c*WORD_W +: WORD_W]),
      .load_pulse (rd_load[c])
    );
  end

endmodule

// File: rtl/tdm_demux_chk.sv
module tdm_demux_chk
  import tdm_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bit_tick,
  input logic                     cap_en,
  input logic                     start_take,
  input logic [IDX_W-1:0]         cur_idx,
  input logic [SIZE_W-1:0]        cfg_frame_size,
  input logic                     cfg_byte_mode,
  input logic                     frame_valid,
  input logic [NUM_CH-1:0]        qual_vec,
  input logic [NUM_CH-1:0]        rd_load,
  input logic [NUM_CH*WORD_W-1:0] rd_data
);

  localparam int HALF_W = WORD_W / 2;

  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (cur_idx <= last_index(cfg_frame_size))); // R1

  AST_NO_LOAD_UNSYNCED: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> (rd_load == '0)); // R2

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R3

  AST_QUAL_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (qual_vec != '0) |-> cap_en); // R4

  AST_RESTART_VALID: assert property (@(posedge clk) disable iff (rst)
    start_take |=> frame_valid); // R11

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_LOAD_AFTER_QUAL: assert property (@(posedge clk) disable iff (rst)
      rd_load[c] |-> $past(qual_vec[c])); // R7

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd_load[c] && $past(cfg_byte_mode)) |->
        (rd_data[c*WORD_W+HALF_W +: (WORD_W-HALF_W)] == '0)); // R8

    AST_HOLD_READ: assert property (@(posedge clk) disable iff (rst)
      (!rd_load[c] && !$past(rst)) |-> $stable(rd_data[c*WORD_W +: WORD_W])); // R9
  end

endmodule

bind tdm_demux tdm_demux_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bit_tick       (bit_tick),
  .cap_en         (cap_en),
  .start_take     (start_take),
  .cur_idx        (cur_idx),
  .cfg_frame_size (cfg_frame_size),
  .cfg_byte_mode  (cfg_byte_mode),
  .frame_valid    (frame_valid),
  .qual_vec       (qual_vec),
  .rd_load        (rd_load),
  .rd_data        (rd_data)
);

// File: tb/test_tdm_demux.sv
module test_tdm_demux;

  localparam int NCH = 16;
  localparam int WW  = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bclk = 1'b0;
  logic               fsync = 1'b0;
  logic               sdata = 1'b0;
  logic [1:0]         cfg_frame_size = '0;
  logic [NCH*8-1:0]   cfg_start = '0;
  logic [NCH*2-1:0]   cfg_len_codes = '0;
  logic               cfg_byte_mode = 1'b0;
  logic [NCH*WW-1:0]  rd_data;
  logic [NCH-1:0]     rd_load;
  logic               frame_valid;

  tdm_demux #(.NUM_CH(NCH), .WORD_W(WW)) i_tdm_demux (
    .clk            (clk),
    .rst            (rst),
    .bclk_in        (bclk),
    .fsync_in       (fsync),
    .sdata_in       (sdata),
    .cfg_frame_size (cfg_frame_size),
    .cfg_start      (cfg_start),
    .cfg_len_codes  (cfg_len_codes),
    .cfg_byte_mode  (cfg_byte_mode),
    .rd_data        (rd_data),
    .rd_load        (rd_load),
    .frame_valid    (frame_valid)
  );

  always #4 clk = ~clk; // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string cur_req = "R7";

  // Reference model state
  int          m_start [NCH];
  int          m_len   [NCH];
  logic [15:0] m_sh    [NCH];
  int          m_got   [NCH];
  logic [15:0] last_exp[NCH];
  bit          m_valid;
  int          m_idx;
  logic [19:0] expq[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_valid = 1'b0;
    m_idx   = 0;
    expq.delete();
    for (int c = 0; c < NCH; c++) begin
      m_sh[c] = '0; m_got[c] = 0; last_exp[c] = '0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; fsync = 1'b0; bclk = 1'b0; sdata = 1'b0;
    repeat (4) @(negedge clk);
    model_clear();
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Driver side of the model: the frame bit that the falling edge delivers
  task automatic model_bit(input logic b, input bit fs);
    int last;
    int tgt;
    logic [15:0] val;
    last = 64 * (int'(cfg_frame_size) + 1) - 1;
    tgt  = cfg_byte_mode ? 8 : 16;
    if (fs) begin
      m_idx = 0; m_valid = 1'b1;
    end else if (m_valid) begin
      m_idx = (m_idx == last) ? 0 : m_idx + 1;
    end else begin
      return;
    end
    for (int c = 0; c < NCH; c++) begin
      if (m_idx >= m_start[c] && m_idx < m_start[c] + m_len[c]) begin
        m_sh[c] = {m_sh[c][14:0], b};
        m_got[c]++;
        if (m_got[c] == tgt) begin
          val = cfg_byte_mode ? {8'h00, m_sh[c][7:0]} : m_sh[c];
          expq.push_back({4'(c), val});
          last_exp[c] = val;
          m_got[c] = 0;
        end
      end
    end
  endtask

  // Data carries the inverted bit while the bit clock is high, true bit before the fall
  task automatic send_bit(input logic b, input bit fs);
    bclk = 1'b1; fsync = fs; sdata = ~b;
    repeat (2) @(negedge clk);
    sdata = b;
    repeat (2) @(negedge clk);
    bclk = 1'b0;
    model_bit(b, fs);
    repeat (4) @(negedge clk);
    fsync = 1'b0;
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic send_frame(input bit with_sync, input int nbits);
    for (int i = 0; i < nbits; i++)
      send_bit(next_bit(), with_sync && (i == 0));
  endtask

  task automatic apply_cfg(input logic [1:0] sz, input logic bm);
    cfg_frame_size = sz;
    cfg_byte_mode  = bm;
    for (int c = 0; c < NCH; c++) begin
      cfg_start[c*8 +: 8]     = 8'(m_start[c]);
      cfg_len_codes[c*2 +: 2] = (m_len[c] == 1) ? 2'd0 : (m_len[c] == 2) ? 2'd1 :
                                (m_len[c] == 4) ? 2'd2 : 2'd3;
    end
  endtask

  task automatic end_phase(input string req);
    repeat (12) @(negedge clk);
    check(expq.size() == 0, "R7", "pending expected loads", expq.size(), 0);
    for (int c = 0; c < NCH; c++)
      check(rd_data[c*WW +: WW] == last_exp[c], req, $sformatf("held word ch%0d", c),
            rd_data[c*WW +: WW], last_exp[c]);
  endtask

  // Monitor: pops expected words as loads appear
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        if (rd_load[c]) begin
          if (expq.size() == 0) begin
            check(1'b0, cur_req, $sformatf("unexpected load ch%0d", c), rd_data[c*WW +: WW], 0);
          end else begin
            logic [19:0] it;
            it = expq.pop_front();
            check(it == {4'(c), rd_data[c*WW +: WW]}, cur_req, "load channel/word",
                  {4'(c), rd_data[c*WW +: WW]}, it);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_start[c] = 0; m_len[c] = 1; end
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    do_reset();
    check(frame_valid == 1'b0, "R10", "frame_valid after reset", frame_valid, 0);
    check(rd_data == '0, "R10", "read registers after reset", rd_data[31:0], 0);

    // Config A: 64-bit frames, all four lengths, 16-bit words (R4, R5, R6, R3)
    for (int c = 0; c < NCH; c++) begin m_start[c] = c * 4; m_len[c] = 1 << (c % 4); end
    apply_cfg(2'd0, 1'b0);
    // R2: bits before any frame sync are ignored
    cur_req = "R2";
    send_frame(1'b0, 40);
    repeat (6) @(negedge clk);
    check(frame_valid == 1'b0, "R2", "frame_valid before sync", frame_valid, 0);
    check(rd_data == '0, "R2", "no capture before sync", rd_data[31:0], 0);
    cur_req = "R5";
    for (int f = 0; f < 16; f++) send_frame(1'b1, 64);
    check(frame_valid == 1'b1, "R2", "frame_valid after sync", frame_valid, 1);
    end_phase("R6");

    // Config B: 128-bit frames, byte mode, start 63 length 2 on ch3 (R4, R8)
    do_reset();
    for (int c = 0; c < NCH; c++) begin m_start[c] = c * 8; m_len[c] = 1 << ((c + 1) % 4); end
    m_start[3] = 63; m_len[3] = 2;
    apply_cfg(2'd1, 1'b1);
    cur_req = "R8";
    for (int f = 0; f < 8; f++) send_frame(1'b1, 128);
    end_phase("R4");

    // Config C: 192-bit frames wrapping without new syncs (R1)
    do_reset();
    for (int c = 0; c < NCH; c++) begin m_start[c] = (c * 37) % 192; m_len[c] = 1 << ((c + 2) % 4); end
    m_start[0] = 0;   m_len[0] = 8;
    m_start[1] = 188; m_len[1] = 4;
    m_start[2] = 190; m_len[2] = 4;
    apply_cfg(2'd2, 1'b0);
    cur_req = "R1";
    send_frame(1'b1, 192);
    for (int f = 0; f < 3; f++) send_frame(1'b0, 192);
    end_phase("R1");

    // Config D: 256-bit frames, mid-frame restart (R11)
    do_reset();
    for (int c = 0; c < NCH; c++) begin m_start[c] = 255 - c * 15; m_len[c] = 8; end
    m_start[0] = 0; m_start[1] = 5; m_start[15] = 255; m_len[15] = 1;
    apply_cfg(2'd3, 1'b1);
    cur_req = "R11";
    send_frame(1'b1, 100);
    send_frame(1'b1, 256);
    send_frame(1'b1, 30);
    send_frame(1'b1, 256);
    end_phase("R11");

    // R9: read registers hold with the line idle and no loads
    for (int i = 0; i < 40; i++) @(negedge clk);
    for (int c = 0; c < NCH; c++)
      check(rd_data[c*WW +: WW] == last_exp[c], "R9", $sformatf("idle hold ch%0d", c),
            rd_data[c*WW +: WW], last_exp[c]);

    // R10: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rd_data == '0, "R10", "read registers cleared", rd_data[31:0], 0);
    check(frame_valid == 1'b0, "R10", "frame_valid cleared", frame_valid, 0);
    rst = 1'b0;
    model_clear();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule